// File: doc/BRIEF.md
# Software-Managed Translation Buffer with Probe

The block holds a small, fully associative set of address translations that privileged software loads, looks up and reads back through register-style commands. Each entry covers a pair of neighbouring virtual pages: one virtual page tag, an address-space identifier, a page-size mask value and a global flag, plus two physical frame descriptors. Each descriptor carries its own valid bit, dirty bit and three-bit cache attribute.

Software puts its operands on the register inputs: the virtual-page register, the two frame registers, the mask register, the index register and a lower bound for random replacement. It then raises a command strobe for one cycle. The command stores an entry at the slot given by the index register, stores one at the slot given by the free-running random counter, searches all entries for the current tag and identifier, or reads one entry back. Every command finishes in a single cycle. A done pulse marks the result registers as updated.

Top module: `soft_tlb`

## Requirements
- R1: While reset is held, random_o is N_ENTRIES-1, done_o is 0, and index_o and all read result outputs are 0. Every entry is cleared: tag, identifier, mask, global flag, valid, dirty, attribute and frame are all zero, so reading a slot that was never written returns zeros.
- R2: Command code 0 (write-indexed) stores the entry in slot index_i modulo N_ENTRIES, which is index_i[3:0] at the default size. Command code 3 (read) selects its slot the same way.
- R3: On a write, the stored global flag is the AND of bit 0 of entry_lo0_i and bit 0 of entry_lo1_i. A read returns that flag in bit 0 of both frame outputs.
- R4: Frame register layout: bit 0 global, bit 1 valid, bit 2 dirty, bits 5:3 cache attribute, bits 31:6 frame number. The physical frame address is the frame number shifted left by 12. A read rebuilds both frame outputs in this layout. entry_hi_o returns the tag (bits 31:13 of the written entry_hi_i) with the identifier (bits 7:0) in bits 7:0 and zeros in bits 12:8.
- R5: Probe (code 2) matches an entry when its tag equals entry_hi_i[31:13] and either the entry is global or its identifier equals entry_hi_i[7:0]. Bits 12:8 of entry_hi_i take no part. When several entries match, the lowest slot number wins.
- R6: On a probe miss, index_o becomes index_i with bit 31 set and bits 30:0 unchanged.
- R7: On a probe hit, index_o becomes the matching slot number, with bit 31 and all other upper bits clear.
- R8: After reset, random_o steps down by one every clock while it is above wired_i. When it is at or below wired_i, it next returns to N_ENTRIES-1.
- R9: Write-random (code 1) stores the entry in the slot that random_o shows in the cycle the command is sampled.
- R10: done_o is high in exactly the cycle after a command is sampled, and done_op_o then shows that command's code. index_o changes only on a probe. The read outputs change only on a read.
- R11: The mask value written with an entry comes back unchanged on page_mask_o when that entry is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe, one cycle per command |
| cmd_op_i | input | 2 | Command code: 0 write-indexed, 1 write-random, 2 probe, 3 read |
| entry_hi_i | input | 32 | Virtual page tag (31:13) and identifier (7:0) |
| entry_lo0_i | input | 32 | Even-page frame descriptor |
| entry_lo1_i | input | 32 | Odd-page frame descriptor |
| page_mask_i | input | 32 | Mask value stored with the entry |
| index_i | input | 32 | Current index register value |
| wired_i | input | IDX_W | Lower bound of the random counter |
| done_o | output | 1 | Command completed in the previous cycle |
| done_op_o | output | 2 | Code of the completed command |
| index_o | output | 32 | Probe result |
| entry_hi_o | output | 32 | Read result: tag and identifier |
| entry_lo0_o | output | 32 | Read result: even-page descriptor |
| entry_lo1_o | output | 32 | Read result: odd-page descriptor |
| page_mask_o | output | 32 | Read result: mask value |
| random_o | output | IDX_W | Random replacement counter |

## Verification
The bench sets up two entries that share one tag. The lower slot is global and the higher slot has a matching identifier. A probe must then return the lower slot, and a design that scanned from the top would return the higher one. One entry has its global bit set in only one frame register. A design that took the OR of the two bits, or took one bit alone, would read back a set global flag and would hit on probes under a foreign identifier. Index values above the entry count check the modulo selection. A design that used the full index would write and read the wrong slot. Probes with bit 31 already set, and probes with tag bits 12:8 set, check that a hit clears bit 31 and that those low tag bits are ignored. The random counter is followed across its wrap with two different lower bounds. A design that stopped one step early or late would break the predicted sequence and would place write-random entries in the wrong slot.

// File: rtl/soft_tlb_pkg.sv
package soft_tlb_pkg;
  localparam int REG_W     = 32;
  localparam int PAGE_LSB  = 13;
  localparam int ASID_W    = 8;
  localparam int CATTR_W   = 3;
  localparam int FRAME_LSB = 6;
  localparam int FRAME_W   = REG_W - FRAME_LSB;
  localparam int VPN_W     = REG_W - PAGE_LSB;
  localparam int GAP_W     = PAGE_LSB - ASID_W;

  typedef enum logic [1:0] {
    OP_WR_IDX = 2'd0,
    OP_WR_RND = 2'd1,
    OP_PROBE  = 2'd2,
    OP_READ   = 2'd3
  } tlb_op_e;

  typedef struct packed {
    logic [FRAME_W-1:0] frame;
    logic [CATTR_W-1:0] cattr;
    logic               dirty;
    logic               valid;
  } frame_desc_t;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [ASID_W-1:0] asid;
    logic [REG_W-1:0]  mask;
    logic              glob;
    frame_desc_t       even;
    frame_desc_t       odd;
  } tlb_entry_t;

  function automatic frame_desc_t unpack_lo(input logic [REG_W-1:0] lo);
    frame_desc_t d;
    d.valid = lo[1];
    d.dirty = lo[2];
    d.cattr = lo[3 +: CATTR_W];
    d.frame = lo[FRAME_LSB +: FRAME_W];
    return d;
  endfunction

  function automatic logic [REG_W-1:0] pack_lo(input frame_desc_t d, input logic g);
    return {d.frame, d.cattr, d.dirty, d.valid, g};
  endfunction
endpackage

// File: rtl/tlb_random.sv
module tlb_random #(
  parameter int N_ENTRIES = 16,
  parameter int IDX_W     = $clog2(N_ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] wired_i,
  output logic [IDX_W-1:0] rnd_o
);
  localparam logic [IDX_W-1:0] TOP = IDX_W'(N_ENTRIES - 1);

  logic [IDX_W-1:0] rnd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              rnd_q <= TOP;
    else if (rnd_q <= wired_i) rnd_q <= TOP;
    else                      rnd_q <= rnd_q - 1'b1;
  end

  assign rnd_o = rnd_q;
endmodule

// File: rtl/tlb_store.sv
module tlb_store
  import soft_tlb_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int IDX_W     = $clog2(N_ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  tlb_entry_t       wr_entry_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output tlb_entry_t       rd_entry_o,
  output tlb_entry_t       ent_o [N_ENTRIES]
);
  tlb_entry_t ent_q [N_ENTRIES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_ENTRIES; i++) ent_q[i] <= '0;
    end else if (we_i) begin
      for (int i = 0; i < N_ENTRIES; i++)
        if (wr_idx_i == IDX_W'(i)) ent_q[i] <= wr_entry_i;
    end
  end

  assign rd_entry_o = ent_q[rd_idx_i];

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_out
    assign ent_o[g] = ent_q[g];
  end
endmodule

// File: rtl/tlb_probe.sv
module tlb_probe
  import soft_tlb_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int IDX_W     = $clog2(N_ENTRIES)
) (
  input  tlb_entry_t        ent_i [N_ENTRIES],
  input  logic [VPN_W-1:0]  vpn_i,
  input  logic [ASID_W-1:0] asid_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  hit_idx_o
);
  logic [N_ENTRIES-1:0] match;

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
    assign match[g] = (ent_i[g].vpn == vpn_i) &&
                      (ent_i[g].glob || (ent_i[g].asid == asid_i));
  end

  // descending scan so the lowest matching slot is left standing
  always_comb begin
    hit_o     = 1'b0;
    hit_idx_o = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_o     = 1'b1;
        hit_idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/soft_tlb.sv
module soft_tlb
  import soft_tlb_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int IDX_W     = $clog2(N_ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [1:0]       cmd_op_i,
  input  logic [31:0]      entry_hi_i,
  input  logic [31:0]      entry_lo0_i,
  input  logic [31:0]      entry_lo1_i,
  input  logic [31:0]      page_mask_i,
  input  logic [31:0]      index_i,
  input  logic [IDX_W-1:0] wired_i,
  output logic             done_o,
  output logic [1:0]       done_op_o,
  output logic [31:0]      index_o,
  output logic [31:0]      entry_hi_o,
  output logic [31:0]      entry_lo0_o,
  output logic [31:0]      entry_lo1_o,
  output logic [31:0]      page_mask_o,
  output logic [IDX_W-1:0] random_o
);
  tlb_op_e          op;
  logic [IDX_W-1:0] rnd;
  logic [IDX_W-1:0] sel_idx;
  logic [IDX_W-1:0] wr_idx;
  logic             we;
  tlb_entry_t       wr_entry;
  tlb_entry_t       rd_entry;
  tlb_entry_t       ents [N_ENTRIES];
  logic             hit;
  logic [IDX_W-1:0] hit_idx;

  assign op      = tlb_op_e'(cmd_op_i);
  assign sel_idx = index_i[IDX_W-1:0];  // modulo for power-of-two size
  assign we      = cmd_valid_i && (op == OP_WR_IDX || op == OP_WR_RND);
  assign wr_idx  = (op == OP_WR_RND) ? rnd : sel_idx;

  always_comb begin
    wr_entry      = '0;
    wr_entry.vpn  = entry_hi_i[REG_W-1:PAGE_LSB];
    wr_entry.asid = entry_hi_i[ASID_W-1:0];
    wr_entry.mask = page_mask_i;
    wr_entry.glob = entry_lo0_i[0] & entry_lo1_i[0];
    wr_entry.even = unpack_lo(entry_lo0_i);
    wr_entry.odd  = unpack_lo(entry_lo1_i);
  end

  tlb_random #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) u_rnd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wired_i(wired_i),
    .rnd_o  (rnd)
  );

  tlb_store #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (we),
    .wr_idx_i  (wr_idx),
    .wr_entry_i(wr_entry),
    .rd_idx_i  (sel_idx),
    .rd_entry_o(rd_entry),
    .ent_o     (ents)
  );

  tlb_probe #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) u_probe (
    .ent_i    (ents),
    .vpn_i    (entry_hi_i[REG_W-1:PAGE_LSB]),
    .asid_i   (entry_hi_i[ASID_W-1:0]),
    .hit_o    (hit),
    .hit_idx_o(hit_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o      <= 1'b0;
      done_op_o   <= '0;
      index_o     <= '0;
      entry_hi_o  <= '0;
      entry_lo0_o <= '0;
      entry_lo1_o <= '0;
      page_mask_o <= '0;
    end else begin
      done_o <= cmd_valid_i;
      if (cmd_valid_i) begin
        done_op_o <= cmd_op_i;
        case (op)
          OP_PROBE: index_o <= hit ? 32'(hit_idx) : (index_i | 32'h8000_0000);
          OP_READ: begin
            entry_hi_o  <= {rd_entry.vpn, {GAP_W{1'b0}}, rd_entry.asid};
            entry_lo0_o <= pack_lo(rd_entry.even, rd_entry.glob);
            entry_lo1_o <= pack_lo(rd_entry.odd, rd_entry.glob);
            page_mask_o <= rd_entry.mask;
          end
          default: ;
        endcase
      end
    end
  end

  assign random_o = rnd;
endmodule

// File: rtl/soft_tlb_chk.sv
module soft_tlb_chk #(
  parameter int N_ENTRIES = 16,
  parameter int IDX_W     = $clog2(N_ENTRIES)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_valid_i,
  input logic [1:0]       cmd_op_i,
  input logic [31:0]      index_i,
  input logic [IDX_W-1:0] wired_i,
  input logic             done_o,
  input logic [1:0]       done_op_o,
  input logic [31:0]      index_o,
  input logic [31:0]      entry_hi_o,
  input logic [31:0]      entry_lo0_o,
  input logic [31:0]      entry_lo1_o,
  input logic [IDX_W-1:0] random_o
);
  p_rnd_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (random_o > wired_i) |=> (32'(random_o) == 32'($past(random_o)) - 1));

  p_rnd_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (random_o <= wired_i) |=> (32'(random_o) == N_ENTRIES - 1));

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |=> (done_o && done_op_o == $past(cmd_op_i)));

  p_done_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> !done_o);

  p_index_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && done_op_o == 2'd2) |-> $stable(index_o));

  p_hit_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && done_op_o == 2'd2 && !index_o[31]) |-> (index_o < 32'(N_ENTRIES)));

  p_miss_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && done_op_o == 2'd2 && index_o[31]) |-> (index_o[30:0] == $past(index_i[30:0])));

  p_read_gap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && done_op_o == 2'd3) |-> (entry_hi_o[12:8] == 5'd0));

  p_read_glob_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && done_op_o == 2'd3) |-> (entry_lo0_o[0] == entry_lo1_o[0]));
endmodule

bind soft_tlb soft_tlb_chk #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmd_valid_i(cmd_valid_i),
  .cmd_op_i   (cmd_op_i),
  .index_i    (index_i),
  .wired_i    (wired_i),
  .done_o     (done_o),
  .done_op_o  (done_op_o),
  .index_o    (index_o),
  .entry_hi_o (entry_hi_o),
  .entry_lo0_o(entry_lo0_o),
  .entry_lo1_o(entry_lo1_o),
  .random_o   (random_o)
);

// File: tb/soft_tlb_tb_top.sv
module soft_tlb_tb_top;
  localparam int N  = 16;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [1:0]    cmd_op = '0;
  logic [31:0]   hi_in = '0, lo0_in = '0, lo1_in = '0, mask_in = '0, idx_in = '0;
  logic [IW-1:0] wired = '0;
  logic          done;
  logic [1:0]    done_op;
  logic [31:0]   idx_out, hi_out, lo0_out, lo1_out, mask_out;
  logic [IW-1:0] rnd;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  soft_tlb #(.N_ENTRIES(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .entry_hi_i(hi_in), .entry_lo0_i(lo0_in), .entry_lo1_i(lo1_in),
    .page_mask_i(mask_in), .index_i(idx_in), .wired_i(wired),
    .done_o(done), .done_op_o(done_op), .index_o(idx_out),
    .entry_hi_o(hi_out), .entry_lo0_o(lo0_out), .entry_lo1_o(lo1_out),
    .page_mask_o(mask_out), .random_o(rnd)
  );

  typedef struct packed {
    logic [1:0]  op;
    logic [31:0] idx, hi, lo0, lo1, mask;
    logic [31:0] e_idx, e_hi, e_lo0, e_lo1, e_mask;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    // R2: slot 0x25 mod 16 = 5; only lo0 bit0 set
    '{2'd0, 32'h25, 32'h0004_BF7C, 32'h0ABC_DE2F, 32'h0123_4566, 32'h6000, 0, 0, 0, 0, 0, 4'd2},
    '{2'd0, 32'h02, 32'h1234_6011, 32'h43, 32'h81, 32'h0, 0, 0, 0, 0, 0, 4'd2},
    '{2'd0, 32'h09, 32'h1234_6022, 32'h02, 32'h04, 32'h0, 0, 0, 0, 0, 0, 4'd2},
    // R3 R4 R11: G dropped to 0, bits 12:8 cleared, mask returned
    '{2'd3, 32'h15, 0, 0, 0, 0, 0, 32'h0004_A07C, 32'h0ABC_DE2E, 32'h0123_4566, 32'h6000, 4'd4},
    '{2'd3, 32'h02, 0, 0, 0, 0, 0, 32'h1234_6011, 32'h43, 32'h81, 32'h0, 4'd3},
    '{2'd3, 32'h09, 0, 0, 0, 0, 0, 32'h1234_6022, 32'h02, 32'h04, 32'h0, 4'd4},
    // R1: never-written slot reads zero
    '{2'd3, 32'h03, 0, 0, 0, 0, 0, 32'h0, 32'h0, 32'h0, 32'h0, 4'd1},
    // R5 R7: global slot 2 hits a foreign identifier
    '{2'd2, 32'hFFFF_FFF0, 32'h1234_6055, 0, 0, 0, 32'h2, 0, 0, 0, 0, 4'd7},
    // R5: slots 2 and 9 both match, lowest wins
    '{2'd2, 32'h0, 32'h1234_6022, 0, 0, 0, 32'h2, 0, 0, 0, 0, 4'd5},
    '{2'd2, 32'h0, 32'h0004_A07C, 0, 0, 0, 32'h5, 0, 0, 0, 0, 4'd5},
    // R6: identifier mismatch on non-global slot
    '{2'd2, 32'h7, 32'h0004_A07D, 0, 0, 0, 32'h8000_0007, 0, 0, 0, 0, 4'd6},
    // R7: hit clears bit 31; tag bits 12:8 ignored
    '{2'd2, 32'h8000_000C, 32'h0004_BF7C, 0, 0, 0, 32'h5, 0, 0, 0, 0, 4'd7},
    '{2'd2, 32'h8000_000C, 32'h0006_A07C, 0, 0, 0, 32'h8000_000C, 0, 0, 0, 0, 4'd6},
    // R3: rewrite slot 2 with lo1 bit0 clear, global lost
    '{2'd0, 32'h02, 32'h1234_6011, 32'h43, 32'h80, 32'h0, 0, 0, 0, 0, 0, 4'd3},
    '{2'd2, 32'h1, 32'h1234_6055, 0, 0, 0, 32'h8000_0001, 0, 0, 0, 0, 4'd3},
    '{2'd2, 32'h0, 32'h1234_6022, 0, 0, 0, 32'h9, 0, 0, 0, 0, 4'd5},
    '{2'd3, 32'h02, 0, 0, 0, 0, 0, 32'h1234_6011, 32'h42, 32'h80, 32'h0, 4'd3}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, sampled at next posedge; results visible at following negedge
  task automatic issue(input logic [1:0] op, input logic [31:0] idx, input logic [31:0] hi,
                       input logic [31:0] l0, input logic [31:0] l1, input logic [31:0] mk);
    cmd_op = op; idx_in = idx; hi_in = hi; lo0_in = l0; lo1_in = l1; mask_in = mk;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R10 done", {31'd0, done}, 32'd1);
    check("R10 op", {30'd0, done_op}, {30'd0, op});
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] last_idx;
    logic [IW-1:0] prev, r;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 random", 32'(rnd), 32'd15);
    check("R1 done", {31'd0, done}, 32'd0);
    check("R1 index", idx_out, 32'd0);
    check("R1 hi", hi_out, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 no done idle", {31'd0, done}, 32'd0);

    last_idx = 32'd0;
    for (int v = 0; v < NV; v++) begin
      issue(VECS[v].op, VECS[v].idx, VECS[v].hi, VECS[v].lo0, VECS[v].lo1, VECS[v].mask);
      if (VECS[v].op == 2'd2) begin
        check($sformatf("R%0d probe v%0d", VECS[v].rq, v), idx_out, VECS[v].e_idx);
        last_idx = VECS[v].e_idx;
      end else begin
        check($sformatf("R10 index held v%0d", v), idx_out, last_idx);
      end
      if (VECS[v].op == 2'd3) begin
        check($sformatf("R%0d hi v%0d", VECS[v].rq, v), hi_out, VECS[v].e_hi);
        check($sformatf("R%0d lo0 v%0d", VECS[v].rq, v), lo0_out, VECS[v].e_lo0);
        check($sformatf("R%0d lo1 v%0d", VECS[v].rq, v), lo1_out, VECS[v].e_lo1);
        check($sformatf("R11 mask v%0d", v), mask_out, VECS[v].e_mask);
      end
    end

    // R8: counter sequence with bound 0, then bound 12
    wired = '0;
    @(negedge clk);
    prev = rnd;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      check("R8 step b0", 32'(rnd), (prev <= wired) ? 32'd15 : 32'(prev) - 1);
      prev = rnd;
    end
    wired = 4'd12;
    @(negedge clk);
    prev = rnd;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      check("R8 step b12", 32'(rnd), (prev <= wired) ? 32'd15 : 32'(prev) - 1);
      prev = rnd;
    end

    // R9: write-random lands in the slot shown when sampled
    for (int k = 0; k < 2; k++) begin
      r = rnd;
      issue(2'd1, 32'h0, 32'hABCD_E0A0 + 32'(k), 32'h0000_0F03, 32'h0000_1005, 32'h0);
      @(negedge clk);
      issue(2'd3, 32'(r), 0, 0, 0, 0);
      check("R9 hi", hi_out, 32'hABCD_E0A0 + 32'(k));
      check("R9 lo0", lo0_out, 32'h0000_0F03);
      check("R9 lo1", lo1_out, 32'h0000_1005);
    end
    // R9: bound keeps writes off low slots
    issue(2'd3, 32'h2, 0, 0, 0, 0);
    check("R9 slot2 intact", hi_out, 32'h1234_6011);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule